// File: doc/BRIEF.md
# Hundredths-Resolution Interval and Watchdog Timer

This block measures programmable intervals in steps of one hundredth of a second. It is driven by a single-cycle enable that pulses once every 10 ms, the same rate that advances the time of day. The host writes the period as four BCD digits through a small byte-wide write port. One byte holds the seconds (00 to 99) and the other holds the hundredths (00 to 99), so a period can run from 00.01 s to 99.99 s. A period of 00.00 keeps the timer idle.

Every write to a period byte restarts timing from the full period. A host that keeps writing the period before it runs out uses the block as a watchdog. A host that lets it run out with repeat enabled gets a periodic interrupt.

When the count runs out, a sticky interrupt flag is set. The flag stays set until the host reads status or writes the acknowledge address. The remaining count is visible on an output.

Top module: `hwt_interval_watchdog`

## Requirements
- R1: After reset the remaining count is 0000, the interrupt output is low and both period bytes hold 00.
- R2: A write to address 0 sets the hundredths byte and a write to address 1 sets the seconds byte. Each byte is two BCD digits. A nibble above 9 is stored as 9. On the clock after any period write, the remaining count equals the complete new period.
- R3: On each clock where the tick is high, the count is nonzero and there is no period write, the count drops by one in decimal, borrowing across digits (0100 becomes 0099). Without a tick the count holds.
- R4: A tick that arrives while the count is 0001 is an expiry. The interrupt output is high on the next clock.
- R5: With repeat enabled, an expiry loads the count with the full period again.
- R6: With repeat disabled, an expiry leaves the count at 0000. The count then ignores ticks until the next period write.
- R7: With a period of 0000, the count stays 0000 and no interrupt is ever raised.
- R8: The interrupt stays high until a status-read pulse or a write to address 2 clears it. An expiry in the same clock as a clear leaves the interrupt high. Writes to address 3 have no effect.
- R9: When a period write and a tick fall on the same clock, the write wins and that tick is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_100hz | input | 1 | One-cycle enable every 10 ms |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 hundredths, 1 seconds, 2 acknowledge |
| wr_data | input | 8 | Write data, BCD for the period bytes |
| status_rd | input | 1 | Status-read pulse, clears the interrupt |
| repeat_en | input | 1 | 1 interval mode (auto reload), 0 one-shot watchdog |
| count_bcd | output | 16 | Remaining count, four BCD digits |
| irq | output | 1 | Sticky interrupt flag |

## Verification
If a digit of the counter holds a wrong value, the error shows on `count_bcd` in the very next cycle. A borrow that goes astray shows on the first tick that crosses a digit boundary. A bad reload or a missing expiry decode shows up as `irq` rising at the wrong tick, or not rising at all. It also shows as a count that fails to return to the period one clock after expiry. A flag that clears itself, or that misses a set when a clear arrives in the same cycle, differs from the expected value one clock after the event. For this reason the bench compares both outputs against its model on every cycle instead of only at the end of a scenario.

// File: rtl/hwt_pkg.sv
package hwt_pkg;

  localparam int unsigned BCD_MAX = 9;

  function automatic logic [3:0] bcd_sat_nib(input logic [3:0] n);
    return (n > 4'(BCD_MAX)) ? 4'(BCD_MAX) : n;
  endfunction

  function automatic logic [7:0] bcd_sat_byte(input logic [7:0] b);
    return {bcd_sat_nib(b[7:4]), bcd_sat_nib(b[3:0])};
  endfunction

endpackage

// File: rtl/hwt_period_regs.sv
module hwt_period_regs #(
  parameter int NBYTE = 2,
  parameter int AW    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [7:0]         wr_data,
  output logic               load,
  output logic               ack,
  output logic [8*NBYTE-1:0] period_d,
  output logic [8*NBYTE-1:0] period_q
);
  import hwt_pkg::*;

  logic [7:0] sat_byte;

  assign sat_byte = bcd_sat_byte(wr_data);
  assign load     = wr_en && (wr_addr < AW'(NBYTE));
  assign ack      = wr_en && (wr_addr == AW'(NBYTE));

  for (genvar g = 0; g < NBYTE; g++) begin : g_byte
    assign period_d[8*g +: 8] = (load && (wr_addr == AW'(g))) ? sat_byte
                                                              : period_q[8*g +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
    end else if (load) begin
      period_q <= period_d;
    end
  end

  AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(period_q)) else $error("period changed without write"); // R2

endmodule

// File: rtl/hwt_bcd_counter.sv
module hwt_bcd_counter #(
  parameter int NDIG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [4*NDIG-1:0] load_val,
  input  logic              tick,
  input  logic              repeat_en,
  input  logic [4*NDIG-1:0] reload_val,
  output logic [4*NDIG-1:0] count_q,
  output logic              expire
);
  localparam int W = 4*NDIG;
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] count_d;
  logic [W-1:0] dec_val;
  logic [NDIG:0] brw;
  logic          nonzero;
  logic          is_one;
  logic          step;

  assign brw[0] = 1'b1;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    logic [3:0] dig;
    assign dig             = count_q[4*g +: 4];
    assign dec_val[4*g +: 4] = !brw[g]       ? dig :
                               (dig == 4'd0) ? 4'd9 : dig - 4'd1;
    assign brw[g+1]        = brw[g] && (dig == 4'd0);

    AST_DIGIT_DECIMAL: assert property (@(posedge clk) disable iff (!rst_n)
      count_q[4*g +: 4] <= 4'd9) else $error("digit out of range"); // R3
  end

  assign nonzero = |count_q;
  assign is_one  = (count_q == ONE);
  assign step    = tick && nonzero && !load;
  assign expire  = step && is_one;

  always_comb begin
    count_d = count_q;
    if (load) begin
      count_d = load_val;
    end else if (expire) begin
      count_d = repeat_en ? reload_val : '0;
    end else if (step) begin
      count_d = dec_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (load || step) begin
      count_q <= count_d;
    end
  end

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count_q == $past(load_val)) else $error("load lost"); // R2
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count_q)) else $error("count moved"); // R3
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0 && !load) |=> count_q == '0) else $error("idle count moved"); // R7

endmodule

// File: rtl/hwt_irq_flag.sv
module hwt_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq
);
  logic irq_d;

  always_comb begin
    irq_d = irq;
    if (set) begin
      irq_d = 1'b1;
    end else if (clr) begin
      irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else if (set || clr) begin
      irq <= irq_d;
    end
  end

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr) |=> irq) else $error("flag dropped"); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> irq) else $error("expiry lost"); // R4
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !set) |=> !irq) else $error("flag rose unprompted"); // R7

endmodule

// File: rtl/hwt_interval_watchdog.sv
module hwt_interval_watchdog #(
  parameter  int NDIG  = 4,
  localparam int NBYTE = NDIG / 2,
  localparam int AW    = $clog2(NBYTE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_100hz,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              status_rd,
  input  logic              repeat_en,
  output logic [4*NDIG-1:0] count_bcd,
  output logic              irq
);
  logic              load;
  logic              ack;
  logic              expire;
  logic [4*NDIG-1:0] period_d;
  logic [4*NDIG-1:0] period_q;

  hwt_period_regs #(.NBYTE(NBYTE), .AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .load     (load),
    .ack      (ack),
    .period_d (period_d),
    .period_q (period_q)
  );

  hwt_bcd_counter #(.NDIG(NDIG)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_val   (period_d),
    .tick       (tick_100hz),
    .repeat_en  (repeat_en),
    .reload_val (period_q),
    .count_q    (count_bcd),
    .expire     (expire)
  );

  hwt_irq_flag u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (expire),
    .clr   (status_rd || ack),
    .irq   (irq)
  );

  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !repeat_en) |=> count_bcd == '0) else $error("one-shot kept running"); // R6
  AST_INTERVAL_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && repeat_en) |=> count_bcd == $past(period_q)) else $error("no reload"); // R5
  AST_WRITE_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (load && tick_100hz) |=> count_bcd == period_q) else $error("tick beat write"); // R9

endmodule

// File: tb/tb_hwt_interval_watchdog.sv
module tb_hwt_interval_watchdog;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_100hz = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        status_rd = 1'b0;
  logic        repeat_en = 1'b0;
  logic [15:0] count_bcd;
  logic        irq;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  // behavioural model state
  int m_hund = 0;
  int m_sec  = 0;
  int m_cnt  = 0;
  bit m_irq  = 0;
  bit m_rep  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hwt_interval_watchdog dut (
    .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .status_rd(status_rd),
    .repeat_en(repeat_en), .count_bcd(count_bcd), .irq(irq)
  );

  function automatic logic [15:0] to_bcd(input int v);
    return {4'(v / 1000), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  function automatic int sat_dec(input logic [7:0] b);
    int hi = (b[7:4] > 9) ? 9 : int'(b[7:4]);
    int lo = (b[3:0] > 9) ? 9 : int'(b[3:0]);
    return hi * 10 + lo;
  endfunction

  task automatic step(input bit t, input bit w, input logic [1:0] a,
                      input logic [7:0] d, input bit r, input string tag);
    int per;
    bit set;
    @(negedge clk);
    vectors++;
    if (count_bcd !== to_bcd(m_cnt) || irq !== m_irq) begin
      miscompares++;
      $display("FAIL %s: count=%h irq=%b expected count=%h irq=%b",
               tag, count_bcd, irq, to_bcd(m_cnt), m_irq);
    end
    tick_100hz = t; wr_en = w; wr_addr = a; wr_data = d;
    status_rd = r; repeat_en = m_rep;
    set = 0;
    if (w && a == 2'd0) m_hund = sat_dec(d);
    if (w && a == 2'd1) m_sec  = sat_dec(d);
    per = m_sec * 100 + m_hund;
    if (w && a < 2'd2) begin
      m_cnt = per;
    end else if (t && m_cnt != 0) begin
      if (m_cnt == 1) begin
        set = 1;
        m_cnt = m_rep ? per : 0;
      end else begin
        m_cnt = m_cnt - 1;
      end
    end
    if (set) m_irq = 1;
    else if (r || (w && a == 2'd2)) m_irq = 0;
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1, 0, 2'd0, 8'h00, 0, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 2'd0, 8'h00, 0, tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
    step(0, 1, a, d, 0, tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      miscompares++;
      $display("FAIL R1: watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3, "R1");
    ticks(3, "R1");

    // one-shot expiry
    m_rep = 0;
    wr(2'd0, 8'h05, "R2");
    ticks(5, "R4");
    ticks(4, "R6");
    idle(2, "R8");
    step(0, 0, 2'd0, 8'h00, 1, "R8");
    idle(2, "R8");

    // borrow across digits
    wr(2'd1, 8'h01, "R2");
    wr(2'd0, 8'h02, "R2");
    ticks(6, "R3");
    idle(3, "R3");
    for (int i = 0; i < 8; i++) begin
      step(i % 2, 0, 2'd0, 8'h00, 0, "R3");
    end
    ticks(100, "R4");
    wr(2'd2, 8'h00, "R8");
    wr(2'd3, 8'h55, "R8");
    idle(2, "R8");

    // interval mode with auto reload
    m_rep = 1;
    wr(2'd1, 8'h00, "R2");
    wr(2'd0, 8'h03, "R2");
    ticks(7, "R5");
    idle(1, "R8");
    ticks(2, "R5");
    step(1, 0, 2'd0, 8'h00, 1, "R8");
    idle(2, "R8");
    step(0, 0, 2'd0, 8'h00, 1, "R8");
    ticks(2, "R5");

    // write against tick
    step(1, 1, 2'd0, 8'h04, 0, "R9");
    ticks(2, "R9");
    step(1, 1, 2'd0, 8'h04, 0, "R9");
    idle(2, "R9");

    // zero period
    step(0, 0, 2'd0, 8'h00, 1, "R8");
    wr(2'd0, 8'h00, "R7");
    ticks(6, "R7");
    m_rep = 0;
    ticks(3, "R7");

    // saturation of non-decimal nibbles
    wr(2'd0, 8'hAF, "R2");
    wr(2'd1, 8'hC3, "R2");
    ticks(5, "R3");
    wr(2'd1, 8'h00, "R2");
    wr(2'd0, 8'h1B, "R2");
    ticks(25, "R4");

    // watchdog refresh holds off expiry
    wr(2'd2, 8'h00, "R8");
    wr(2'd0, 8'h04, "R2");
    for (int k = 0; k < 6; k++) begin
      ticks(3, "R6");
      wr(2'd0, 8'h04, "R2");
    end
    ticks(6, "R6");
    idle(2, "R6");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule